// File: doc/BRIEF.md
# Filtered Edge-Selectable Interrupt Front End

This block sits between a set of external interrupt pins and the interrupt controller of a chip. Each pin first passes through a two-flop synchronizer. A digital glitch filter then suppresses short pulses: the filter output takes a new level only after the synchronized input has held that level for a set number of consecutive clock cycles. If the input returns to the old level before then, the count starts again. A per-pin polarity select chooses whether the rising or the falling transition of the filtered signal counts as an event.

Each event sets a sticky per-source latch. Software reads the latch and clears a bit by writing 1 to it. One pin, the noisy one, has a selectable filter length of 63 or 15 cycles. Every other pin uses a short fixed filter. One pin is shared with a general-purpose port and raises events only when it is switched to interrupt use and its port direction is input. The combined request is the OR of every latch ANDed with its own enable, and a master enable then gates that OR.

Top module: `eint_frontend`

## Requirements
- R1: While reset is high and after it is released, every latch reads 0 and the request output is 0.
- R2: With `noise_short_i` = 0, a pulse on pin 1 shorter than 63 clock cycles sets no latch, and a pulse of 63 cycles or more sets latch bit 1.
- R3: With `noise_short_i` = 1, a pulse on pin 1 shorter than 15 cycles sets no latch, and a pulse of 15 cycles or more sets latch bit 1.
- R4: `edge_fall_i[i]` = 0 selects the rising edge of pin i and 1 selects the falling edge. The unselected edge leaves the latch unchanged.
- R5: Pin 0 sets its latch only while both `pin0_irq_en_i` and `pin0_dir_in_i` are 1. Pulses seen at any other time are lost.
- R6: A 1 on `clr_i[i]` for one cycle clears latch bit i. Bits whose `clr_i` bit is 0 keep their value.
- R7: If an edge event and a clear for the same bit fall on the same clock edge, the latch stays set.
- R8: `irq_o` equals `master_en_i` AND the OR over all i of (`latch_o[i]` AND `src_en_i[i]`).
- R9: Pins other than pin 1 use a fixed filter of 2 cycles: a 1-cycle pulse is rejected and a 2-cycle pulse is accepted.
- R10: A bounce back to the old level, even for a single cycle, restarts the filter count. Two 40-cycle high segments split by a 1-cycle low set no latch in the 63-cycle mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pin_i | input | 4 | Asynchronous external pin levels |
| edge_fall_i | input | 4 | Per-pin polarity: 0 rising, 1 falling |
| noise_short_i | input | 1 | Pin 1 filter length: 0 selects 63 cycles, 1 selects 15 |
| pin0_irq_en_i | input | 1 | Pin 0 used as an interrupt input |
| pin0_dir_in_i | input | 1 | Pin 0 port direction is input |
| src_en_i | input | 4 | Individual source enables |
| master_en_i | input | 1 | Master request enable |
| clr_i | input | 4 | Write-1-to-clear pulses for the latches |
| latch_o | output | 4 | Latch state |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: four pins, the noisy filter on pin 1 at 63 and 15 cycles, the port-shared pin at index 0 and a 2-cycle base filter. With these values, pulses of exactly 62/63 and 14/15 cycles can be applied within the cycle budget, so both noisy-filter boundaries are exercised exactly. The short base filter makes the total pin-to-latch latency small enough to predict. The bench can therefore place a clear on the same edge at which a latch sets, and it confirms that the latch is still empty one cycle before that edge.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    localparam int unsigned DEF_LONG_LIMIT  = 63;
    localparam int unsigned DEF_SHORT_LIMIT = 15;
    localparam int unsigned DEF_BASE_LIMIT  = 2;

    typedef struct packed {
        logic      level;
        logic      prev;
        edge_pol_e pol;
        logic      gate;
    } edge_view_t;

    // Filter length for the noisy pin, chosen by the short-select bit.
    function automatic int unsigned pick_limit(input logic short_sel,
                                               input int unsigned long_lim,
                                               input int unsigned short_lim);
        return short_sel ? short_lim : long_lim;
    endfunction

    // Event for one pin from the previous and current filtered level.
    function automatic logic edge_hit(input edge_view_t v);
        logic rise, fall;
        rise = v.level & ~v.prev;
        fall = ~v.level & v.prev;
        return v.gate & ((v.pol == EDGE_FALL) ? fall : rise);
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int unsigned NP = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NP-1:0] async_i,
    output logic [NP-1:0] sync_o
);
    logic [NP-1:0] stage1_q;
    logic [NP-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/eint_glitch_filter.sv
module eint_glitch_filter #(
    parameter int unsigned CW = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          din_i,
    input  logic [CW-1:0] limit_i,
    output logic          dout_o
);
    logic [CW-1:0] run_q;
    logic          level_q;
    logic [CW:0]   run_next;

    assign run_next = {1'b0, run_q} + {{CW{1'b0}}, 1'b1};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (din_i == level_q) begin
            // Input agrees with the output (or bounced back): restart.
            run_q <= '0;
        end else if (run_next >= {1'b0, limit_i}) begin
            level_q <= din_i;
            run_q   <= '0;
        end else begin
            run_q <= run_next[CW-1:0];
        end
    end

    assign dout_o = level_q;
endmodule

// File: rtl/eint_edge_latch.sv
module eint_edge_latch
    import eint_pkg::*;
#(
    parameter int unsigned NP = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NP-1:0] level_i,
    input  logic [NP-1:0] fall_sel_i,
    input  logic [NP-1:0] gate_i,
    input  logic [NP-1:0] clr_i,
    output logic [NP-1:0] latch_o
);
    logic [NP-1:0] prev_q;
    logic [NP-1:0] hit;
    logic [NP-1:0] latch_q;

    for (genvar g = 0; g < NP; g++) begin : g_hit
        edge_view_t view;
        always_comb begin
            view.level = level_i[g];
            view.prev  = prev_q[g];
            view.pol   = edge_pol_e'(fall_sel_i[g]);
            view.gate  = gate_i[g];
            hit[g]     = edge_hit(view);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= level_i;
            // A new event outranks a clear in the same cycle.
            latch_q <= (latch_q & ~clr_i) | hit;
        end
    end

    assign latch_o = latch_q;
endmodule

// File: rtl/eint_frontend.sv
module eint_frontend
    import eint_pkg::*;
#(
    parameter int unsigned NP          = 4,
    parameter int unsigned NOISY_IDX   = 1,
    parameter int unsigned PORT_IDX    = 0,
    parameter int unsigned LONG_LIMIT  = DEF_LONG_LIMIT,
    parameter int unsigned SHORT_LIMIT = DEF_SHORT_LIMIT,
    parameter int unsigned BASE_LIMIT  = DEF_BASE_LIMIT
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NP-1:0] pin_i,
    input  logic [NP-1:0] edge_fall_i,
    input  logic          noise_short_i,
    input  logic          pin0_irq_en_i,
    input  logic          pin0_dir_in_i,
    input  logic [NP-1:0] src_en_i,
    input  logic          master_en_i,
    input  logic [NP-1:0] clr_i,
    output logic [NP-1:0] latch_o,
    output logic          irq_o
);
    localparam int unsigned MAXLIM = (LONG_LIMIT > SHORT_LIMIT) ?
                                     ((LONG_LIMIT > BASE_LIMIT) ? LONG_LIMIT : BASE_LIMIT) :
                                     ((SHORT_LIMIT > BASE_LIMIT) ? SHORT_LIMIT : BASE_LIMIT);
    localparam int unsigned CW = $clog2(MAXLIM + 1);

    logic [NP-1:0] synced;
    logic [NP-1:0] filtered;
    logic [NP-1:0] gate;
    logic [NP-1:0] latch;

    eint_sync #(.NP(NP)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (pin_i),
        .sync_o  (synced)
    );

    for (genvar g = 0; g < NP; g++) begin : g_pin
        logic [CW-1:0] limit;
        if (g == NOISY_IDX) begin : g_noisy
            assign limit = CW'(pick_limit(noise_short_i, LONG_LIMIT, SHORT_LIMIT));
        end else begin : g_base
            assign limit = CW'(BASE_LIMIT);
        end

        if (g == PORT_IDX) begin : g_port
            assign gate[g] = pin0_irq_en_i & pin0_dir_in_i;
        end else begin : g_plain
            assign gate[g] = 1'b1;
        end

        eint_glitch_filter #(.CW(CW)) u_filt (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .din_i   (synced[g]),
            .limit_i (limit),
            .dout_o  (filtered[g])
        );
    end

    eint_edge_latch #(.NP(NP)) u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .level_i    (filtered),
        .fall_sel_i (edge_fall_i),
        .gate_i     (gate),
        .clr_i      (clr_i),
        .latch_o    (latch)
    );

    assign latch_o = latch;
    assign irq_o   = master_en_i & (|(latch & src_en_i));
endmodule

// File: rtl/eint_frontend_chk.sv
module eint_frontend_chk #(
    parameter int unsigned NP = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          pin0_irq_en_i,
    input logic          pin0_dir_in_i,
    input logic [NP-1:0] src_en_i,
    input logic          master_en_i,
    input logic [NP-1:0] clr_i,
    input logic [NP-1:0] latch_o,
    input logic          irq_o
);
    // Reset empties the latches (R1).
    assert_reset_empty_R1: assert property (@(posedge clk_i)
        rst_i |=> (latch_o == '0));

    // No request without the master enable (R8).
    assert_master_gate_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !master_en_i |-> !irq_o);

    // A request needs an enabled set latch (R8).
    assert_needs_source_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (|(latch_o & src_en_i)));

    // The shared pin sets its latch only while configured as an interrupt input (R5).
    assert_port_gate_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(latch_o[0]) |-> $past(pin0_irq_en_i & pin0_dir_in_i));

    for (genvar g = 0; g < NP; g++) begin : g_clr
        // A latch only drops after a clear on its bit (R6).
        assert_clear_only_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(latch_o[g]) |-> $past(clr_i[g]));
    end
endmodule

bind eint_frontend eint_frontend_chk #(.NP(NP)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .pin0_irq_en_i (pin0_irq_en_i),
    .pin0_dir_in_i (pin0_dir_in_i),
    .src_en_i      (src_en_i),
    .master_en_i   (master_en_i),
    .clr_i         (clr_i),
    .latch_o       (latch_o),
    .irq_o         (irq_o)
);

// File: tb/sim_eint_frontend.sv
`timescale 1ns/1ps
module sim_eint_frontend;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin, edge_fall, src_en, clr;
    logic          noise_short, p0_en, p0_dir, master_en;
    logic [NP-1:0] latch;
    logic          irq;

    always #2.5 clk = ~clk;

    eint_frontend u0 (
        .clk_i(clk), .rst_i(rst), .pin_i(pin), .edge_fall_i(edge_fall),
        .noise_short_i(noise_short), .pin0_irq_en_i(p0_en), .pin0_dir_in_i(p0_dir),
        .src_en_i(src_en), .master_en_i(master_en), .clr_i(clr),
        .latch_o(latch), .irq_o(irq)
    );

    typedef struct {
        string         req;
        logic [NP-1:0] exp_latch;
        logic          exp_irq;
    } item_t;

    item_t         sb_q[$];
    event          sb_ev;
    int            checks = 0;
    int            failures = 0;
    logic [NP-1:0] model = '0;
    bit            done = 0;

    // Driver side: expected state from the requirements, pushed to the scoreboard.
    task automatic expect_now(input string req);
        item_t it;
        it.req       = req;
        it.exp_latch = model;
        it.exp_irq   = master_en & (|(model & src_en));
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    // Monitor side: pops expectations and compares them with the outputs.
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (latch !== it.exp_latch || irq !== it.exp_irq) begin
                    failures++;
                    $display("FAIL %s latch=%b irq=%b expected latch=%b irq=%b",
                             it.req, latch, irq, it.exp_latch, it.exp_irq);
                end
            end
        end
    end

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Drive pin p to level lvl for len cycles, then back, then let filters settle.
    task automatic pulse(input int p, input logic lvl, input int len);
        @(negedge clk);
        pin[p] = lvl;
        cycles(len);
        pin[p] = ~lvl;
        cycles(80);
    endtask

    task automatic clear(input logic [NP-1:0] m);
        @(negedge clk);
        clr = m;
        @(negedge clk);
        clr = '0;
        model = model & ~m;
    endtask

    initial begin
        rst = 1'b1; pin = '0; edge_fall = '0; src_en = '1; clr = '0;
        noise_short = 1'b0; p0_en = 1'b1; p0_dir = 1'b1; master_en = 1'b1;
        cycles(4);
        expect_now("R1 during reset");
        rst = 1'b0;
        cycles(3);
        expect_now("R1 after reset");

        // R2: 63-cycle mode on pin 1
        pulse(1, 1'b1, 62);
        expect_now("R2 62-cycle pulse rejected");
        pulse(1, 1'b1, 63);
        model[1] = 1'b1;
        expect_now("R2 63-cycle pulse accepted");
        clear(4'b0010);

        // R10: bounce restarts the count
        @(negedge clk);
        pin[1] = 1'b1; cycles(40);
        pin[1] = 1'b0; cycles(1);
        pin[1] = 1'b1; cycles(40);
        pin[1] = 1'b0; cycles(80);
        expect_now("R10 bounced 40+40 rejected");

        // R3: 15-cycle mode
        noise_short = 1'b1;
        pulse(1, 1'b1, 14);
        expect_now("R3 14-cycle pulse rejected");
        pulse(1, 1'b1, 15);
        model[1] = 1'b1;
        expect_now("R3 15-cycle pulse accepted");
        clear(4'b0010);
        noise_short = 1'b0;

        // R9: base filter on pin 2
        pulse(2, 1'b1, 1);
        expect_now("R9 1-cycle pulse rejected");
        pulse(2, 1'b1, 2);
        model[2] = 1'b1;
        expect_now("R9 2-cycle pulse accepted");

        // R6: clearing another bit leaves bit 2, then clear bit 2
        clear(4'b1001);
        expect_now("R6 unrelated clear keeps bit 2");
        clear(4'b0100);
        expect_now("R6 write-1 clear");

        // R4: falling-edge select on pin 3
        edge_fall[3] = 1'b1;
        @(negedge clk);
        pin[3] = 1'b1; cycles(12);
        expect_now("R4 rising edge ignored under falling select");
        pin[3] = 1'b0; cycles(12);
        model[3] = 1'b1;
        expect_now("R4 falling edge latched");

        // R8: request gating
        src_en = 4'b0111;
        expect_now("R8 individual enable off");
        src_en = 4'b1000; master_en = 1'b0;
        expect_now("R8 master enable off");
        master_en = 1'b1;
        expect_now("R8 both enables on");
        clear(4'b1000);
        src_en = '1;
        expect_now("R8 request drops after clear");

        // R5: port-shared pin 0
        p0_en = 1'b0; p0_dir = 1'b1;
        pulse(0, 1'b1, 5);
        expect_now("R5 pin enable off");
        p0_en = 1'b1; p0_dir = 1'b0;
        pulse(0, 1'b1, 5);
        expect_now("R5 direction output");
        p0_dir = 1'b1;
        pulse(0, 1'b1, 5);
        model[0] = 1'b1;
        expect_now("R5 enabled input pin latches");
        clear(4'b0001);

        // R7: clear on the same edge that sets bit 2 (sync 2 + filter 2 + latch 1)
        @(negedge clk);
        pin[2] = 1'b1;
        cycles(4);
        expect_now("R7 latch not yet set");
        clr = 4'b0100;
        @(negedge clk);
        clr = '0;
        model[2] = 1'b1;
        expect_now("R7 set wins over clear");
        pin[2] = 1'b0;
        cycles(10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule